// File: doc/BRIEF.md
# Three-Wire Serial Control Port with Panel Register Bank

This block is the device end of a serial control port for a display driver. It uses three pins: a serial clock, an active-low select and one data line that both sides share. The host opens a frame by lowering the select. It then sends a register address and a direction flag. On a write, the host follows with a data byte. On a read, the line goes idle for one clock and the block then returns a byte.

All three port pins pass through synchronisers into the system clock domain, and the block finds the serial clock edges there. A frame sequencer turns the bit stream into single-cycle register strobes. A register bank holds four registers:
- a scratch register for link testing,
- a fixed identification byte,
- a resolution code,
- a control byte that holds the power state and the ownership bit.

The ownership bit picks where the chip takes its resolution and power state from: the register bank or the strap inputs.

The shared data line appears as a separate input, an output value and an output enable. An I/O cell at the chip edge combines them.

Top module: `spi3_panel_regs`

## Requirements
- R1: A frame begins with six address bits, most significant bit first, followed by a direction bit where 1 selects read and 0 selects write; bits are sampled on rising serial clock edges while select is low.
- R2: In a write frame the eighth clock carries a pad bit whose value has no effect; clocks 9 to 16 carry the data byte, most significant bit first, and the register updates only once the sixteenth rising edge is seen.
- R3: In a read frame the block leaves the line undriven up to and during the eighth clock, drives the reply most significant bit first with each new bit after a falling edge starting with the eighth, releases the line after the sixteenth falling edge, and never drives while select is high or in a write frame.
- R4: Address 0 is an 8-bit scratch register; any written value reads back unchanged.
- R5: Address 1 reads {CHIP_ID in bits 7:4, CHIP_REV in bits 3:0}; writes to it are discarded.
- R6: Address 2 holds the resolution code in bits 2:0; its bits 7:3 read as zero.
- R7: Address 3 holds the power bit in bit 0 (1 = active, 0 = standby) and the ownership bit in bit 7; bits 6:1 read as zero.
- R8: With the ownership bit at 1, `resolution` and `panelActive` follow address 2 and address 3 bit 0; with it at 0 they follow `strapRes` and `strapActive`.
- R9: `dualScan` is high exactly when the resolution code in use is 0 or 1.
- R10: Reads of addresses 4 to 63 return 0x00, and writes to them change no register.
- R11: A frame ended by select rising before the sixteenth clock changes no register.
- R12: While reset is low the port ignores traffic and the line is released; afterwards scratch reads 0x00, address 2 reads RES_DEFAULT (7), and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low frame select |
| sdaIn | input | 1 | Value present on the shared data line |
| sdaOut | output | 1 | Data value the block drives during a read reply |
| sdaOe | output | 1 | Enable for the block's driver on the data line |
| strapRes | input | 3 | Strapped resolution code, used when the ownership bit is 0 |
| strapActive | input | 1 | Strapped power state, used when the ownership bit is 0 |
| resolution | output | 3 | Resolution code in use |
| panelActive | output | 1 | Power state in use (1 = active) |
| dualScan | output | 1 | High when the resolution code in use is a dual-scan code |

## Verification
The assertions assume two things about the host:
- it holds each serial clock phase for well over the synchroniser depth plus two system clocks;
- it changes the data line only while the serial clock is low, so every edge and every bit is seen cleanly.

The bench host keeps each phase at eight system clocks and drives the line on the low phase only. It lets go of the line from the eighth clock of a read onward, so driver overlap can be checked at every sample. Random frames mix reads and writes, random pad bits and random addresses across the whole 6-bit space. Directed frames cover truncation, reset in mid-frame and strap switching.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/spi3_frame_ctrl.sv
module spi3_frame_ctrl
  import spi3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rdData,
  output regStrobe_t        strobe,
  output logic              sdaOut,
  output logic              sdaOe
);
  localparam int FRAME = ADDR_W + 2 + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_DIR   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_TURN  = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME);
  localparam logic [2:0]       LANE_RST  = 3'b010;  // lane 0 sclk, 1 csN, 2 data

  logic [2:0] rawIn;
  logic [2:0] syncOut;
  assign rawIn = {sdaIn, csN, sclk};

  for (genvar g = 0; g < 3; g++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {SYNC_STAGES{LANE_RST[g]}};
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[SYNC_STAGES-1];
  end

  logic sclkS, csS, sdaS, sclkPrev;
  assign sclkS = syncOut[0];
  assign csS   = syncOut[1];
  assign sdaS  = syncOut[2];

  logic sclkRise, sclkFall;
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;

  logic [CNT_W-1:0]  bitCnt;
  logic              isRead;
  logic [ADDR_W-1:0] addrSh;
  logic [DATA_W-1:0] dataSh;
  logic [DATA_W-2:0] txSh;
  logic              wrEn;
  logic              outBit;
  logic              oe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      addrSh   <= '0;
      dataSh   <= '0;
      txSh     <= '0;
      wrEn     <= 1'b0;
      outBit   <= 1'b0;
      oe       <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      wrEn     <= 1'b0;
      if (csS) begin
        bitCnt <= '0;
        isRead <= 1'b0;
        oe     <= 1'b0;
      end else begin
        if (sclkRise && bitCnt != CNT_FULL) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt < CNT_DIR)        addrSh <= {addrSh[ADDR_W-2:0], sdaS};
          else if (bitCnt == CNT_DIR)  isRead <= sdaS;
          else if (bitCnt >= CNT_TURN) dataSh <= {dataSh[DATA_W-2:0], sdaS};
          if (bitCnt == CNT_LAST && !isRead) wrEn <= 1'b1;
        end
        if (sclkFall && isRead) begin
          if (bitCnt == CNT_TURN) begin
            oe     <= 1'b1;
            outBit <= rdData[DATA_W-1];
            txSh   <= rdData[DATA_W-2:0];
          end else if (bitCnt > CNT_TURN && bitCnt < CNT_FULL) begin
            outBit <= txSh[DATA_W-2];
            txSh   <= {txSh[DATA_W-3:0], 1'b0};
          end else if (bitCnt == CNT_FULL) begin
            oe <= 1'b0;
          end
        end
      end
    end
  end

  assign strobe.wrEn   = wrEn;
  assign strobe.addr   = addrSh;
  assign strobe.wrData = dataSh;
  assign sdaOut        = outBit;
  assign sdaOe         = oe;

  // R3: select high releases the line on the next cycle
  a_r3_release_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !sdaOe);
  // R3: the driver is only on inside a read frame
  a_r3_drive_only_read: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> isRead);
  // R2, R11: commit only after a full write frame
  a_r2_commit_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (bitCnt == CNT_FULL && !isRead));
  // R11: one commit per frame
  a_r11_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
endmodule

// File: rtl/spi3_reg_bank.sv
module spi3_reg_bank
  import spi3_pkg::*;
#(
  parameter logic [3:0] CHIP_ID     = 4'hA,
  parameter logic [3:0] CHIP_REV    = 4'h3,
  parameter logic [2:0] RES_DEFAULT = 3'd7
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [2:0]        strapRes,
  input  logic              strapActive,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        resolution,
  output logic              panelActive,
  output logic              dualScan
);
  localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RES     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(3);
  localparam int PWR_BIT = 0;
  localparam int OWN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] scratchReg;
  logic [2:0]        resReg;
  logic              pwrReg;
  logic              ownReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchReg <= '0;
      resReg     <= RES_DEFAULT;
      pwrReg     <= 1'b0;
      ownReg     <= 1'b0;
    end else if (strobe.wrEn) begin
      case (strobe.addr)
        A_SCRATCH: scratchReg <= strobe.wrData;
        A_RES:     resReg     <= strobe.wrData[2:0];
        A_CTRL: begin
          pwrReg <= strobe.wrData[PWR_BIT];
          ownReg <= strobe.wrData[OWN_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.addr)
      A_SCRATCH: rdData = scratchReg;
      A_IDENT:   rdData = {CHIP_ID, CHIP_REV};
      A_RES:     rdData[2:0] = resReg;
      A_CTRL: begin
        rdData[PWR_BIT] = pwrReg;
        rdData[OWN_BIT] = ownReg;
      end
      default: rdData = '0;
    endcase
  end

  assign resolution  = ownReg ? resReg : strapRes;
  assign panelActive = ownReg ? pwrReg : strapActive;
  assign dualScan    = (resolution[2:1] == 2'b00);

  // R10: writes to unmapped addresses leave every register alone
  a_r10_unmapped_discard: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr > A_CTRL) |=>
      ($stable(scratchReg) && $stable(resReg) && $stable(pwrReg) && $stable(ownReg)));
  // R5: writes to the identification address leave every register alone
  a_r5_ident_discard: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.addr == A_IDENT) |=>
      ($stable(scratchReg) && $stable(resReg) && $stable(pwrReg) && $stable(ownReg)));
  // R11: without a commit strobe no register moves
  a_r11_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> ($stable(scratchReg) && $stable(resReg) && $stable(pwrReg) && $stable(ownReg)));
endmodule

// File: rtl/spi3_panel_regs.sv
module spi3_panel_regs
  import spi3_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] CHIP_ID     = 4'hA,
  parameter logic [3:0] CHIP_REV    = 4'h3,
  parameter logic [2:0] RES_DEFAULT = 3'd7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdaIn,
  output logic       sdaOut,
  output logic       sdaOe,
  input  logic [2:0] strapRes,
  input  logic       strapActive,
  output logic [2:0] resolution,
  output logic       panelActive,
  output logic       dualScan
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] rdData;

  spi3_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdaIn(sdaIn),
    .rdData(rdData), .strobe(strobe), .sdaOut(sdaOut), .sdaOe(sdaOe)
  );

  spi3_reg_bank #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .RES_DEFAULT(RES_DEFAULT)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .strapRes(strapRes),
    .strapActive(strapActive), .rdData(rdData), .resolution(resolution),
    .panelActive(panelActive), .dualScan(dualScan)
  );
endmodule

// File: tb/test_spi3_panel_regs.sv
module test_spi3_panel_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [7:0] ID_BYTE = 8'hA3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, hostOe = 1'b0, hostBit = 1'b0;
  logic [2:0] strapRes = 3'd4;
  logic strapActive = 1'b0;
  logic sdaOut, sdaOe, panelActive, dualScan;
  logic [2:0] resolution;
  logic sdaLine;

  int errors = 0;
  int checks = 0;

  logic [7:0] mScratch;
  logic [2:0] mRes;
  logic       mPwr, mOwn;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = hostOe ? hostBit : (sdaOe ? sdaOut : 1'b1);

  spi3_panel_regs i_spi3_panel_regs (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdaIn(sdaLine),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .strapRes(strapRes), .strapActive(strapActive),
    .resolution(resolution), .panelActive(panelActive), .dualScan(dualScan)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [5:0] a);
    case (a)
      6'd0: return mScratch;
      6'd1: return ID_BYTE;
      6'd2: return {5'b0, mRes};
      6'd3: return {mOwn, 6'b0, mPwr};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void modelWrite(input logic [5:0] a, input logic [7:0] d);
    case (a)
      6'd0: mScratch = d;
      6'd2: mRes = d[2:0];
      6'd3: begin mOwn = d[7]; mPwr = d[0]; end
      default: ;
    endcase
  endfunction

  function automatic void modelReset();
    mScratch = 8'h00; mRes = 3'd7; mPwr = 1'b0; mOwn = 1'b0;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame; nClk below 16 truncates it
  task automatic frame(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                       input logic pad, input int nClk, output logic [7:0] got);
    logic [6:0] hdr;
    hdr = {a, rd};
    got = 8'h00;
    @(negedge clk); csN = 1'b0;
    for (int i = 0; i < nClk; i++) begin
      if (i < 7) begin hostOe = 1'b1; hostBit = hdr[6-i]; end
      else if (!rd) begin hostOe = 1'b1; hostBit = (i == 7) ? pad : wd[15-i]; end
      else hostOe = 1'b0;
      waitN(HALF);
      check(!(hostOe && sdaOe), "R3 contention", int'(sdaOe), 0);
      if (rd && i >= 8) got[15-i] = sdaLine;
      if (rd && i < 8) check(!sdaOe, "R3 undriven before reply", int'(sdaOe), 0);
      sclk = 1'b1;
      waitN(HALF);
      if (rd && i == 7) check(!sdaOe, "R3 turnaround released", int'(sdaOe), 0);
      sclk = 1'b0;
    end
    waitN(HALF);
    if (rd && nClk == 16) check(!sdaOe, "R3 released after reply", int'(sdaOe), 0);
    csN = 1'b1; hostOe = 1'b0;
    waitN(HALF);
    check(!sdaOe, "R3 idle released", int'(sdaOe), 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic pad);
    logic [7:0] dummy;
    frame(1'b0, a, d, pad, 16, dummy);
    modelWrite(a, d);
  endtask

  task automatic rdCheck(input logic [5:0] a, input string req);
    logic [7:0] got;
    frame(1'b1, a, 8'h00, 1'b0, 16, got);
    check(got == expRead(a), req, int'(got), int'(expRead(a)));
  endtask

  task automatic outCheck(input string req);
    logic [2:0] eRes;
    logic eAct;
    eRes = mOwn ? mRes : strapRes;
    eAct = mOwn ? mPwr : strapActive;
    check(resolution == eRes, req, int'(resolution), int'(eRes));
    check(panelActive == eAct, req, int'(panelActive), int'(eAct));
    check(dualScan == (eRes <= 3'd1), {req, " R9"}, int'(dualScan), int'(eRes <= 3'd1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    int unsigned seedv;
    seedv = $urandom(32'h5EED_0042);
    modelReset();
    waitN(5);
    check(!sdaOe, "R12 line released in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    waitN(5);
    outCheck("R12 reset outputs R8");
    rdCheck(6'd0, "R12 scratch default R1");
    rdCheck(6'd2, "R12 res default");
    rdCheck(6'd3, "R12 ctrl default");
    rdCheck(6'd1, "R5 ident read");

    wr(6'd0, 8'h55, 1'b1);
    rdCheck(6'd0, "R4 scratch 0x55 R2 pad one");
    wr(6'd0, 8'hAA, 1'b0);
    rdCheck(6'd0, "R4 scratch 0xAA R2 pad zero");

    wr(6'd1, 8'h00, 1'b0);
    rdCheck(6'd1, "R5 ident write discarded");

    wr(6'd2, 8'hFD, 1'b0);
    rdCheck(6'd2, "R6 upper bits zero");
    outCheck("R8 strap while not owned");
    strapRes = 3'd1; strapActive = 1'b1; waitN(2);
    outCheck("R8 strap follows R9");

    wr(6'd3, 8'h81, 1'b1);
    rdCheck(6'd3, "R7 ctrl 0x81");
    waitN(2); outCheck("R8 owned by register");
    wr(6'd3, 8'h7F, 1'b0);
    rdCheck(6'd3, "R7 middle bits zero");
    waitN(2); outCheck("R8 returned to straps");
    wr(6'd3, 8'h80, 1'b0);
    for (int c = 0; c < 8; c++) begin
      wr(6'd2, 8'(c), 1'b0);
      waitN(2); outCheck("R9 dual scan decode");
    end

    wr(6'd0, 8'h3C, 1'b0);
    wr(6'd63, 8'hFF, 1'b1);
    wr(6'd4, 8'hFF, 1'b1);
    rdCheck(6'd63, "R10 unmapped reads zero");
    rdCheck(6'd5, "R10 unmapped reads zero");
    rdCheck(6'd0, "R10 scratch untouched");
    rdCheck(6'd2, "R10 res untouched");
    rdCheck(6'd3, "R10 ctrl untouched");

    frame(1'b0, 6'd0, 8'hC3, 1'b0, 15, junk);
    rdCheck(6'd0, "R11 cut at 15 clocks");
    frame(1'b0, 6'd3, 8'h01, 1'b0, 10, junk);
    rdCheck(6'd3, "R11 cut at 10 clocks");
    frame(1'b1, 6'd0, 8'h00, 1'b0, 11, junk);
    rdCheck(6'd0, "R11 cut read harmless");

    for (int k = 0; k < 60; k++) begin
      logic [5:0] a;
      a = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 5);
      if ($urandom % 2) wr(a, 8'($urandom), 1'($urandom));
      else rdCheck(a, "R1 random read");
      if (k % 10 == 9) begin waitN(2); outCheck("R8 random outputs"); end
    end

    // reset in the middle of a write frame
    wr(6'd0, 8'h99, 1'b0);
    @(negedge clk); csN = 1'b0;
    for (int i = 0; i < 5; i++) begin
      hostOe = 1'b1; hostBit = 1'b0;
      waitN(HALF); sclk = 1'b1; waitN(HALF); sclk = 1'b0;
    end
    rstN = 1'b0;
    for (int i = 0; i < 11; i++) begin
      hostBit = 1'($urandom);
      waitN(HALF); sclk = 1'b1; waitN(HALF); sclk = 1'b0;
    end
    check(!sdaOe, "R12 released during reset", int'(sdaOe), 0);
    csN = 1'b1; hostOe = 1'b0;
    waitN(4); rstN = 1'b1; modelReset(); waitN(4);
    rdCheck(6'd0, "R12 scratch after mid-frame reset");
    rdCheck(6'd2, "R12 res after mid-frame reset");
    rdCheck(6'd3, "R12 ctrl after mid-frame reset");
    outCheck("R12 outputs after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule